// File: doc/BRIEF.md
# Fractional-Step Serial Clock Generator

This block derives the serial clock of a high-speed SPI master from a fast reference clock. An 11-bit phase accumulator advances by a programmable step on every reference cycle. The modulus is 2048, and each wrap of the accumulator is one full serial-clock period. The serial clock rate is therefore `step/2048` of the reference rate, and a step that does not divide 2048 exactly gives a fractional average rate. Software sets the step to 2048 divided by the rounded-up ratio of reference to target rate.

Alongside the clock, the block issues two one-cycle strobes to the shift engine: a launch strobe (drive the next output bit) and a latch strobe (sample the input bit). Each strobe follows either the rising or the falling edge of the pin-level clock, chosen independently. The configuration also sets the idle polarity, a clock-gate enable and a restart option that zeroes the phase at each transfer start. A further option handles fast transfers whose input is not sampled synchronously: it moves the latch strobe one reference cycle behind its clock edge.

A four-state controller sequences the output. The states are `ST_IDLE` (no transfer), `ST_GATED` (transfer active, gate closed), `ST_ARM` (waiting for the phase to wrap) and `ST_RUN` (clock toggling). The transitions are as follows:
- From IDLE, an active transfer goes to GATED if the gate is closed, to RUN on a restart, and to ARM otherwise.
- From GATED, an open gate goes to ARM, or to RUN on a restart.
- From ARM, a wrap or a restart goes to RUN.
- From GATED, ARM or RUN, the loss of the active flag returns to IDLE.
- From ARM or RUN, a closed gate goes to GATED.

Top module: `sck_accum_gen`

## Requirements
- R1: The accumulator wraps modulo 2048. Starting from phase 0 with step `F`, the rising edges within 2047 further reference cycles number `floor((2047*F-1024)/2048)+1` (300 for `F`=300). With `F`=256 the period is exactly 8 cycles and each high phase lasts 4 cycles.
- R2: Steps of 1024 and above are limited to 1024, so the clock toggles on every reference cycle, with a period of 2 cycles.
- R3: With `cfg_rst_loop`=1, a `xfer_start` pulse zeroes the phase. The first leading edge is registered at the `1024/F`-th clock edge after the edge that sampled the start (the 4th for `F`=256).
- R4: With `cfg_launch_rise`=1, `launch_stb` pulses in the cycle in which `sck` rises. With 0, it pulses in the cycle in which `sck` falls.
- R5: With `cfg_latch_rise`=1, `latch_stb` pulses with the rising edge of `sck`. With 0, it pulses with the falling edge.
- R6: `cfg_cpol` sets the idle level of `sck`. With `cfg_cpol`=1, the leading phase crossing is a falling pin edge.
- R7: While `cfg_gate_en`=0, `sck` does not toggle and neither strobe pulses, even during a transfer.
- R8: One cycle after `xfer_active` is sampled low, `sck` equals `cfg_cpol` and both strobes are low.
- R9: Each strobe is one reference cycle wide and never appears without its selected `sck` edge.
- R10: With `cfg_async_in`=1, `latch_stb` pulses one reference cycle after its selected `sck` edge.
- R11: Without a restart, the clock starts only after the free-running phase wraps, so the first high phase is full length.
- R12: During reset, `sck`, `launch_stb` and `latch_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | One-cycle pulse at the first cycle of a transfer |
| xfer_active | input | 1 | High for the whole transfer |
| freq_word | input | 14 | Phase step per reference cycle |
| cfg_rst_loop | input | 1 | Zero the phase on `xfer_start` |
| cfg_launch_rise | input | 1 | Launch on rising (1) or falling (0) pin edge |
| cfg_latch_rise | input | 1 | Latch on rising (1) or falling (0) pin edge |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_gate_en | input | 1 | Clock gate open |
| cfg_async_in | input | 1 | Delay latch strobe by one reference cycle |
| sck | output | 1 | Serial clock |
| launch_stb | output | 1 | Launch strobe |
| latch_stb | output | 1 | Latch strobe |

## Verification
A corrupted accumulator shows up at the pins within one serial period: the next half- or full-period crossing comes early or late, so high-phase widths and edge counts drift from `2048/F`. A wrong controller state is visible within a cycle. Examples are toggling while the gate is closed, a clock that stays idle during an active transfer, or a truncated first high pulse. A mis-selected edge map is exposed at the first strobe, which then coincides with the wrong pin edge or with none.

// File: rtl/sckgen_pkg.sv
`timescale 1ns/1ps
package sckgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATED = 2'd1,
        ST_ARM   = 2'd2,
        ST_RUN   = 2'd3
    } sck_state_e;

endpackage

// File: rtl/sckgen_phase_accum.sv
`timescale 1ns/1ps
module sckgen_phase_accum #(
    parameter int FREQ_W  = 14,
    parameter int PHASE_W = 11
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic [FREQ_W-1:0]  freq_word,
    input  logic               restart,
    output logic               lvl_next,
    output logic               cross_half,
    output logic               cross_full,
    output logic               wrap_raw
);

    localparam int SUM_W = PHASE_W + 1;
    localparam logic [SUM_W-1:0] HALF_STEP = SUM_W'(1) << (PHASE_W - 1);

    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] acc_d;
    logic [SUM_W-1:0]   step;
    logic [SUM_W-1:0]   sum;

    generate
        if (FREQ_W >= PHASE_W) begin : g_clamp
            localparam logic [FREQ_W-1:0] HALF_F = FREQ_W'(1) << (PHASE_W - 1);
            always_comb begin
                if (freq_word >= HALF_F) step = HALF_STEP;
                else                     step = SUM_W'(freq_word);
            end
        end else begin : g_narrow
            always_comb step = SUM_W'(freq_word);
        end
    endgenerate

    always_comb begin
        sum        = {1'b0, acc_q} + step;
        wrap_raw   = sum[PHASE_W];
        cross_half = !restart && !acc_q[PHASE_W-1] && sum[PHASE_W-1];
        cross_full = !restart && sum[PHASE_W];
        acc_d      = restart ? '0 : sum[PHASE_W-1:0];
        lvl_next   = acc_d[PHASE_W-1];
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R2: with the step limited to half the modulus a wrap always lands in the lower half
    a_r2_wrap_lands_low: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cross_full |=> !acc_q[PHASE_W-1]);

endmodule

// File: rtl/sckgen_ctrl_fsm.sv
`timescale 1ns/1ps
module sckgen_ctrl_fsm
    import sckgen_pkg::*;
(
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       active,
    input  logic       gate_en,
    input  logic       restart,
    input  logic       wrap,
    output sck_state_e state_q,
    output sck_state_e state_d
);

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (active) begin
                    if (!gate_en)     state_d = ST_GATED;
                    else if (restart) state_d = ST_RUN;
                    else              state_d = ST_ARM;
                end
            end
            ST_GATED: begin
                if (!active)      state_d = ST_IDLE;
                else if (gate_en) state_d = restart ? ST_RUN : ST_ARM;
            end
            ST_ARM: begin
                if (!active)              state_d = ST_IDLE;
                else if (!gate_en)        state_d = ST_GATED;
                else if (restart || wrap) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!active)       state_d = ST_IDLE;
                else if (!gate_en) state_d = ST_GATED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R7: the running state is only reached with the gate open
    a_r7_run_needs_gate: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == ST_RUN) |-> $past(gate_en));

endmodule

// File: rtl/sckgen_edge_map.sv
`timescale 1ns/1ps
module sckgen_edge_map
    import sckgen_pkg::*;
(
    input  logic       clk_ref,
    input  logic       rst_n,
    input  sck_state_e state_q,
    input  sck_state_e state_d,
    input  logic       lvl_next,
    input  logic       cross_half,
    input  logic       cross_full,
    input  logic       cpol,
    input  logic       launch_rise,
    input  logic       latch_rise,
    input  logic       async_in,
    output logic       sck_q,
    output logic       launch_q,
    output logic       latch_q
);

    logic run_d, in_run;
    logic lead_ev, trail_ev, rise_ev, fall_ev;
    logic launch_ev, latch_ev, latch_dly_q;

    always_comb begin
        run_d     = (state_d == ST_RUN);
        in_run    = (state_q == ST_RUN) && run_d;
        lead_ev   = in_run && cross_half;
        trail_ev  = in_run && cross_full;
        rise_ev   = cpol ? trail_ev : lead_ev;
        fall_ev   = cpol ? lead_ev  : trail_ev;
        launch_ev = launch_rise ? rise_ev : fall_ev;
        latch_ev  = latch_rise  ? rise_ev : fall_ev;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            sck_q       <= 1'b0;
            launch_q    <= 1'b0;
            latch_q     <= 1'b0;
            latch_dly_q <= 1'b0;
        end else begin
            sck_q       <= run_d ? (lvl_next ^ cpol) : cpol;
            launch_q    <= launch_ev;
            latch_dly_q <= latch_ev;
            latch_q     <= async_in ? (latch_dly_q && run_d) : latch_ev;
        end
    end

    // R9: a launch pulse always coincides with a pin edge
    a_r9_launch_on_edge: assert property (@(posedge clk_ref) disable iff (!rst_n)
        launch_q |-> (sck_q != $past(sck_q)));

    // R10: a delayed latch pulse follows a pin edge by one cycle
    a_r10_async_latch_lag: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (latch_q && async_in && $past(async_in)) |-> ($past(sck_q) != $past(sck_q, 2)));

    // R11: entering the running state from arming starts at the idle level
    a_r11_arm_entry_idle: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((state_q == ST_RUN) && ($past(state_q) == ST_ARM)) |-> (sck_q == $past(cpol)));

endmodule

// File: rtl/sck_accum_gen.sv
`timescale 1ns/1ps
module sck_accum_gen
    import sckgen_pkg::*;
#(
    parameter int FREQ_W  = 14,
    parameter int PHASE_W = 11
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_active,
    input  logic [FREQ_W-1:0] freq_word,
    input  logic              cfg_rst_loop,
    input  logic              cfg_launch_rise,
    input  logic              cfg_latch_rise,
    input  logic              cfg_cpol,
    input  logic              cfg_gate_en,
    input  logic              cfg_async_in,
    output logic              sck,
    output logic              launch_stb,
    output logic              latch_stb
);

    logic       restart;
    logic       lvl_next, cross_half, cross_full, wrap_raw;
    sck_state_e state_q, state_d;

    assign restart = xfer_start && cfg_rst_loop;

    sckgen_phase_accum #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_accum (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .freq_word  (freq_word),
        .restart    (restart),
        .lvl_next   (lvl_next),
        .cross_half (cross_half),
        .cross_full (cross_full),
        .wrap_raw   (wrap_raw)
    );

    sckgen_ctrl_fsm u_fsm (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .active  (xfer_active),
        .gate_en (cfg_gate_en),
        .restart (restart),
        .wrap    (wrap_raw),
        .state_q (state_q),
        .state_d (state_d)
    );

    sckgen_edge_map u_edges (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .state_q     (state_q),
        .state_d     (state_d),
        .lvl_next    (lvl_next),
        .cross_half  (cross_half),
        .cross_full  (cross_full),
        .cpol        (cfg_cpol),
        .launch_rise (cfg_launch_rise),
        .latch_rise  (cfg_latch_rise),
        .async_in    (cfg_async_in),
        .sck_q       (sck),
        .launch_q    (launch_stb),
        .latch_q     (latch_stb)
    );

    // R8: one cycle after the transfer ends the pins are idle
    a_r8_idle_after_drop: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !xfer_active |=> (sck == $past(cfg_cpol) && !launch_stb && !latch_stb));

    // R7: a closed gate yields no strobes on the next cycle
    a_r7_gate_blocks_strobes: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !cfg_gate_en |=> (!launch_stb && !latch_stb));

    // R3: a restart leaves the clock at its idle level with no launch
    a_r3_restart_phase: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (restart && xfer_active && cfg_gate_en) |=> (sck == $past(cfg_cpol) && !launch_stb));

    // R12: outputs are low while reset is held
    always_comb begin
        if (!rst_n) a_r12_reset_low: assert (!sck && !launch_stb && !latch_stb);
    end

endmodule

// File: tb/sck_accum_gen_tb.sv
`timescale 1ns/1ps
module sck_accum_gen_tb_top;

    logic        clk_ref = 1'b0;
    logic        rst_n;
    logic        xfer_start, xfer_active;
    logic [13:0] freq_word;
    logic        cfg_rst_loop, cfg_launch_rise, cfg_latch_rise;
    logic        cfg_cpol, cfg_gate_en, cfg_async_in;
    logic        sck, launch_stb, latch_stb;

    int nchk = 0, nfail = 0;
    int nrise, nfall, nl, nt, mism, hi_run, exp_hi;
    bit mon_en = 1'b0;
    logic prev_sck = 1'b0, prev_rose = 1'b0, prev_fell = 1'b0;

    always #2 clk_ref = ~clk_ref;

    sck_accum_gen dut_i (
        .clk_ref(clk_ref), .rst_n(rst_n), .xfer_start(xfer_start),
        .xfer_active(xfer_active), .freq_word(freq_word),
        .cfg_rst_loop(cfg_rst_loop), .cfg_launch_rise(cfg_launch_rise),
        .cfg_latch_rise(cfg_latch_rise), .cfg_cpol(cfg_cpol),
        .cfg_gate_en(cfg_gate_en), .cfg_async_in(cfg_async_in),
        .sck(sck), .launch_stb(launch_stb), .latch_stb(latch_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        nrise = 0; nfall = 0; nl = 0; nt = 0; mism = 0; hi_run = 0;
    endtask

    task automatic tick();
        logic r, f, el, et;
        @(posedge clk_ref);
        @(negedge clk_ref);
        r = !prev_sck && sck;
        f = prev_sck && !sck;
        if (mon_en) begin
            el = cfg_launch_rise ? r : f;
            if (cfg_async_in) et = cfg_latch_rise ? prev_rose : prev_fell;
            else              et = cfg_latch_rise ? r : f;
            if (launch_stb !== el) mism++;
            if (latch_stb !== et)  mism++;
            if (r) nrise++;
            if (f) nfall++;
            if (launch_stb) nl++;
            if (latch_stb)  nt++;
            if (sck) hi_run++;
            if (f) begin
                if (exp_hi != 0 && hi_run != exp_hi) mism++;
                hi_run = 0;
            end
        end
        prev_sck = sck; prev_rose = r; prev_fell = f;
    endtask

    task automatic start_xfer();
        xfer_active = 1'b1; xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
    endtask

    task automatic stop_xfer(input string tag);
        mon_en = 1'b0;
        xfer_active = 1'b0;
        tick();
        chk({tag, " R8 sck idle after drop"}, int'(sck), int'(cfg_cpol));
        chk({tag, " R8 strobes low after drop"}, int'(launch_stb | latch_stb), 0);
    endtask

    task automatic cfg(input int fw, input bit rl, input bit lr, input bit ltr,
                       input bit pol, input bit gate, input bit asy, input int hi);
        freq_word = 14'(fw); cfg_rst_loop = rl; cfg_launch_rise = lr;
        cfg_latch_rise = ltr; cfg_cpol = pol; cfg_gate_en = gate;
        cfg_async_in = asy; exp_hi = hi;
    endtask

    task automatic t_reset();
        chk("R12 sck in reset", int'(sck), 0);
        chk("R12 launch in reset", int'(launch_stb), 0);
        chk("R12 latch in reset", int'(latch_stb), 0);
    endtask

    task automatic t_idle();
        cfg(256, 1, 1, 0, 0, 1, 0, 4);
        clr(); mon_en = 1'b1;
        for (int i = 0; i < 30; i++) tick();
        mon_en = 1'b0;
        chk("R8 no edges without transfer", nrise + nfall, 0);
        chk("R8 no strobes without transfer", nl + nt, 0);
    endtask

    task automatic t_restart();
        cfg(256, 1, 1, 0, 0, 1, 0, 4);
        clr(); mon_en = 1'b1;
        start_xfer();
        for (int i = 1; i <= 60; i++) begin
            tick();
            if (i == 3) chk("R3 sck low before first edge", int'(sck), 0);
            if (i == 4) begin
                chk("R3 first rise at 4th edge", int'(sck), 1);
                chk("R4 launch with first rise", int'(launch_stb), 1);
            end
        end
        chk("R1 rises in 61 samples", nrise, 8);
        chk("R1 falls in 61 samples", nfall, 7);
        chk("R9 strobe/edge/width mismatches", mism, 0);
        stop_xfer("restart");
    endtask

    task automatic t_fraction();
        cfg(300, 1, 1, 0, 0, 1, 0, 0);
        clr(); mon_en = 1'b1;
        start_xfer();
        for (int i = 0; i < 2047; i++) tick();
        chk("R1 fractional rises", nrise, 300);
        chk("R1 fractional falls", nfall, 299);
        chk("R9 fractional mismatches", mism, 0);
        stop_xfer("fraction");
    endtask

    task automatic t_fast(input int fw, input string tag);
        cfg(fw, 1, 1, 0, 0, 1, 0, 1);
        clr(); mon_en = 1'b1;
        start_xfer();
        for (int i = 0; i < 40; i++) tick();
        chk({tag, " R2 rises"}, nrise, 20);
        chk({tag, " R2 falls"}, nfall, 20);
        chk({tag, " R2 mismatches"}, mism, 0);
        stop_xfer(tag);
    endtask

    task automatic t_edge_select();
        cfg(512, 1, 0, 1, 0, 1, 0, 2);
        clr(); mon_en = 1'b1;
        start_xfer();
        for (int i = 0; i < 32; i++) tick();
        chk("R4 launch on falling edges", nl, 8);
        chk("R5 latch on rising edges", nt, 8);
        chk("R5 edge-select mismatches", mism, 0);
        stop_xfer("edgesel");
    endtask

    task automatic t_cpol();
        cfg(256, 1, 1, 0, 1, 1, 0, 0);
        mon_en = 1'b0;
        tick();
        chk("R6 idle level high", int'(sck), 1);
        clr(); mon_en = 1'b1;
        start_xfer();
        for (int i = 1; i <= 60; i++) begin
            tick();
            if (i == 4) begin
                chk("R6 leading crossing is a falling pin edge", int'(sck), 0);
                chk("R5 latch on that falling edge", int'(latch_stb), 1);
            end
        end
        chk("R6 pin falls", nfall, 8);
        chk("R6 pin rises", nrise, 7);
        chk("R6 mismatches", mism, 0);
        stop_xfer("cpol");
    endtask

    task automatic t_gate();
        cfg(256, 0, 1, 0, 0, 0, 0, 4);
        clr(); mon_en = 1'b1;
        start_xfer();
        for (int i = 0; i < 40; i++) tick();
        chk("R7 no edges with gate closed", nrise + nfall, 0);
        chk("R7 no strobes with gate closed", nl + nt, 0);
        cfg_gate_en = 1'b1;
        for (int i = 0; i < 40; i++) tick();
        chk("R7 clock runs once gate opens", int'(nrise >= 3), 1);
        chk("R11 full first pulse after gate opens", mism, 0);
        stop_xfer("gate");
    endtask

    task automatic t_freerun();
        cfg(256, 0, 1, 0, 0, 1, 0, 4);
        clr(); mon_en = 1'b1;
        start_xfer();
        for (int i = 0; i < 60; i++) tick();
        chk("R11 clock started", int'(nrise >= 6), 1);
        chk("R11 no truncated pulse or stray strobe", mism, 0);
        stop_xfer("freerun");
    endtask

    task automatic t_async();
        cfg(256, 1, 0, 1, 0, 1, 1, 4);
        clr(); mon_en = 1'b1;
        start_xfer();
        for (int i = 0; i < 60; i++) tick();
        chk("R10 delayed latch count", nt, 7);
        chk("R10 delayed latch alignment", mism, 0);
        stop_xfer("async");
    endtask

    initial begin
        #600000;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; xfer_start = 1'b0; xfer_active = 1'b0;
        cfg(256, 1, 1, 0, 0, 1, 0, 0);
        @(negedge clk_ref);
        @(negedge clk_ref);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_idle();
        t_restart();
        t_fraction();
        t_fast(1024, "step1024");
        t_fast(9000, "step9000");
        t_edge_select();
        t_cpol();
        cfg_cpol = 1'b0; mon_en = 1'b0; tick();
        t_gate();
        t_freerun();
        t_async();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule